// File: doc/BRIEF.md
# Framed Serial Command Word Receiver

This block takes 16-bit command words from a three-wire serial port: a serial clock, a frame-sync and a data line. It runs on a fast system clock and treats all three serial pins as plain asynchronous inputs. Each pin passes through a synchroniser, and the block then looks for edges on the synchronised copies. Bits are taken on falling edges of the serial clock, most significant bit first. When a word is complete, the block raises a one-cycle strobe and presents the 16-bit word: a 4-bit address in bits 15:12 and 12 data bits in bits 11:0. Decoding of the word is left to the logic downstream.

A mode input selects one of two framing rules. In microcontroller framing (`mode_uc`=1), frame-sync must stay low for all 16 bits. The word is delivered on the frame-sync rising edge that follows the 16th bit, and a frame-sync rise before the 16th bit throws the word away. In DSP framing (`mode_uc`=0), the port must first see a falling serial clock edge while frame-sync is high. Frame-sync may then return high early, and the word is delivered on the 16th falling edge. A separate daisy-chain output repeats the data line delayed by 16 serial clocks when `chain_en` is set, so several receivers can share one bus.

The framing state machine has four states. IDLE waits for a frame. ARMED is used in DSP framing only, once the qualifying clock edge has been seen. SHIFT collects bits. HOLD is used in microcontroller framing only: all 16 bits are in and the block waits for frame-sync to rise. The transitions are:
- IDLE→SHIFT on a frame-sync fall in microcontroller framing.
- IDLE→ARMED on a serial clock fall with frame-sync high in DSP framing.
- ARMED→SHIFT on a frame-sync fall.
- SHIFT→SHIFT (restart) on a frame-sync fall in DSP framing.
- SHIFT→IDLE (abort) on a frame-sync rise in microcontroller framing.
- SHIFT→IDLE (deliver) on the 16th fall in DSP framing.
- SHIFT→HOLD on the 16th fall in microcontroller framing.
- HOLD→IDLE (deliver) on a frame-sync rise.

Top module: `serial_word_rx`

## Requirements
- R1: After reset, `word_valid` and `chain_out` are low and no word is delivered until a valid frame completes. The delay line is cleared, so with `chain_en`=1 the first 16 falling serial clock edges after reset bring out 0.
- R2: A delivered word holds the 16 bits in arrival order, the first bit in `word_data[15]`. `word_data` changes only in the cycle where `word_valid` is high.
- R3: In microcontroller framing, a frame starts on a frame-sync fall with no prior serial clock edge needed.
- R4: In microcontroller framing, the word is delivered only after frame-sync rises following the 16th falling edge, never at the 16th edge itself.
- R5: In microcontroller framing, a frame-sync rise before the 16th falling edge discards the word: nothing is delivered.
- R6: In DSP framing, a frame-sync fall that was not preceded by a falling serial clock edge with frame-sync high starts no frame.
- R7: In DSP framing, the word is delivered on the 16th falling edge, even when frame-sync went high earlier in the frame.
- R8: In DSP framing, a frame-sync fall in the middle of a frame restarts the bit count, and the word is made of the 16 bits that follow it.
- R9: `word_valid` is high for exactly one system clock per delivered word.
- R10: With `chain_en`=1, after falling serial clock edge k the output shows the data bit sampled at edge k-16. The delay line shifts on every falling edge, whether or not a frame is active.
- R11: With `chain_en`=0, `chain_out` is low one system clock later and stays low.
- R12: In microcontroller framing, extra falling serial clock edges between the 16th bit and the frame-sync rise are ignored: the delivered word is the one from the first 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| mode_uc | input | 1 | 1 selects microcontroller framing, 0 selects DSP framing |
| chain_en | input | 1 | Enables the daisy-chain output |
| sclk_in | input | 1 | Serial clock, asynchronous |
| fs_in | input | 1 | Frame-sync, active low, asynchronous |
| din_in | input | 1 | Serial data, asynchronous |
| word_valid | output | 1 | One-cycle strobe for a delivered word |
| word_data | output | 16 | Delivered word: address in 15:12, data in 11:0 |
| chain_out | output | 1 | Data line delayed by 16 serial clocks, or low when disabled |

## Verification
The assertions assume that the serial clock, frame-sync and data line change no more often than every few system clocks. They also assume that frame-sync and data never change in the same system clock as a falling serial clock edge, and that `mode_uc` changes only while no frame is in progress. The bench drives every serial pin on the falling system clock edge and holds each level for five system clocks. It changes frame-sync and data only while the serial clock is high, or while it is low with no edge pending. It changes the mode only after a frame has been delivered or discarded and the port has gone quiet. Its random frames vary the framing mode, the word, the abort point, the point where frame-sync rises early, and the number of surplus clock edges.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } rx_state_t;

    // Bit positions of the synchronised pin vector
    localparam int PIN_SCLK = 0;
    localparam int PIN_FS   = 1;
    localparam int PIN_DIN  = 2;
    localparam int PIN_CNT  = 3;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_uc,
    input  logic              fs_lvl,
    input  logic              fs_fall,
    input  logic              fs_rise,
    input  logic              sclk_fall,
    input  logic              din_lvl,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);

    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

    rx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shreg_q;
    logic              last_bit;
    logic              start_frame;
    logic              take_bit;
    logic              deliver_dsp;
    logic              deliver_uc;

    assign last_bit = (cnt_q == LAST_CNT);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mode_uc && fs_fall) begin
                    state_d = ST_SHIFT;
                end else if (!mode_uc && sclk_fall && fs_lvl) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (fs_fall) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (mode_uc && fs_rise) begin
                    state_d = ST_IDLE;
                end else if (!mode_uc && fs_fall) begin
                    state_d = ST_SHIFT;
                end else if (sclk_fall && last_bit) begin
                    state_d = mode_uc ? ST_HOLD : ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (fs_rise) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // Datapath control
    always_comb begin
        start_frame = 1'b0;
        take_bit    = 1'b0;
        deliver_dsp = 1'b0;
        deliver_uc  = 1'b0;
        unique case (state_q)
            ST_IDLE:  start_frame = mode_uc && fs_fall;
            ST_ARMED: start_frame = fs_fall;
            ST_SHIFT: begin
                if (mode_uc && fs_rise) begin
                    take_bit = 1'b0;
                end else if (!mode_uc && fs_fall) begin
                    start_frame = 1'b1;
                end else if (sclk_fall) begin
                    take_bit    = 1'b1;
                    deliver_dsp = !mode_uc && last_bit;
                end
            end
            ST_HOLD:  deliver_uc = fs_rise;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shift register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (start_frame) begin
            cnt_q <= '0;
        end else if (take_bit) begin
            shreg_q <= {shreg_q[WORD_W-2:0], din_lvl};
            cnt_q   <= last_bit ? '0 : cnt_q + 1'b1;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= deliver_dsp || deliver_uc;
            if (deliver_dsp) begin
                word_data <= {shreg_q[WORD_W-2:0], din_lvl};
            end else if (deliver_uc) begin
                word_data <= shreg_q;
            end
        end
    end

endmodule

// File: rtl/rx_chain_delay.sv
module rx_chain_delay #(
    parameter int DELAY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift,
    input  logic bit_in,
    input  logic enable,
    output logic bit_out
);

    localparam int STAGES = DELAY + 1;

    logic [STAGES-1:0] line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (shift) begin
            line_q <= {line_q[STAGES-2:0], bit_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_out <= 1'b0;
        end else begin
            bit_out <= enable && line_q[STAGES-1];
        end
    end

endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
    import serial_rx_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int CHAIN_DELAY = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_uc,
    input  logic              chain_en,
    input  logic              sclk_in,
    input  logic              fs_in,
    input  logic              din_in,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              chain_out
);

    localparam logic [PIN_CNT-1:0] PIN_RST = PIN_CNT'(1) << PIN_FS;

    logic [PIN_CNT-1:0] pins_s;
    logic [1:0]         prev_q;
    logic               sclk_s;
    logic               fs_s;
    logic               din_s;
    logic               sclk_fall;
    logic               fs_fall;
    logic               fs_rise;

    rx_sync #(
        .WIDTH   (PIN_CNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({din_in, fs_in, sclk_in}),
        .sync_out (pins_s)
    );

    assign sclk_s = pins_s[PIN_SCLK];
    assign fs_s   = pins_s[PIN_FS];
    assign din_s  = pins_s[PIN_DIN];

    // Previous levels for edge detection: bit 0 serial clock, bit 1 frame-sync
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 2'b10;
        end else begin
            prev_q <= {fs_s, sclk_s};
        end
    end

    assign sclk_fall = prev_q[0] && !sclk_s;
    assign fs_fall   = prev_q[1] && !fs_s;
    assign fs_rise   = !prev_q[1] && fs_s;

    rx_frame_fsm #(
        .WORD_W (WORD_W)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_uc    (mode_uc),
        .fs_lvl     (fs_s),
        .fs_fall    (fs_fall),
        .fs_rise    (fs_rise),
        .sclk_fall  (sclk_fall),
        .din_lvl    (din_s),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    rx_chain_delay #(
        .DELAY (CHAIN_DELAY)
    ) i_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (sclk_fall),
        .bit_in  (din_s),
        .enable  (chain_en),
        .bit_out (chain_out)
    );

endmodule

// File: rtl/serial_word_rx_chk.sv
module serial_word_rx_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_uc,
    input logic              chain_en,
    input logic              word_valid,
    input logic [WORD_W-1:0] word_data,
    input logic              chain_out,
    input logic              fs_lvl,
    input logic              sclk_fall
);

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R9

    AST_WORD_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_data) |-> word_valid); // R2

    AST_UC_DELIVER_FS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && mode_uc) |-> fs_lvl); // R4

    AST_DSP_DELIVER_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !mode_uc) |-> $past(sclk_fall)); // R7

    AST_CHAIN_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(chain_en) |-> !chain_out); // R11

    AST_CHAIN_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chain_en) && $past(chain_en, 2) && !$stable(chain_out))
            |-> $past(sclk_fall, 2)); // R10

endmodule

bind serial_word_rx serial_word_rx_chk #(
    .WORD_W (WORD_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_uc    (mode_uc),
    .chain_en   (chain_en),
    .word_valid (word_valid),
    .word_data  (word_data),
    .chain_out  (chain_out),
    .fs_lvl     (fs_s),
    .sclk_fall  (sclk_fall)
);

// File: tb/test_serial_word_rx.sv
`timescale 1ns/1ps
module test_serial_word_rx;

    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_uc = 1'b1;
    logic        chain_en = 1'b0;
    logic        sclk = 1'b0;
    logic        fs = 1'b1;
    logic        din = 1'b0;
    logic        word_valid;
    logic [15:0] word_data;
    logic        chain_out;

    int n_checks = 0;
    int n_errors = 0;
    int got_cnt  = 0;
    int dbl_cnt  = 0;
    logic [15:0] got_word = '0;
    logic        prev_valid = 1'b0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    serial_word_rx i_serial_word_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_uc    (mode_uc),
        .chain_en   (chain_en),
        .sclk_in    (sclk),
        .fs_in      (fs),
        .din_in     (din),
        .word_valid (word_valid),
        .word_data  (word_data),
        .chain_out  (chain_out)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid) begin
                got_cnt  = got_cnt + 1;
                got_word = word_data;
            end
            if (word_valid && prev_valid) dbl_cnt = dbl_cnt + 1;
            prev_valid = word_valid;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input logic b);
        din  = b;
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
        wait_clk(HALF);
    endtask

    function automatic bit uc_delivers(input int nbits);
        return nbits == 16;
    endfunction

    task automatic uc_frame(input logic [15:0] w, input int nbits, input int extra);
        fs = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) tick(w[15-i]);
        if (nbits == 16) for (int i = 0; i < extra; i++) tick(~w[i]);
        fs = 1'b1;
        wait_clk(3*HALF);
    endtask

    task automatic dsp_frame(input logic [15:0] w, input int early);
        fs = 1'b1;
        tick(1'b0);
        fs = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 16; i++) begin
            if (i == early) fs = 1'b1;
            tick(w[15-i]);
        end
        fs = 1'b1;
        wait_clk(3*HALF);
    endtask

    task automatic expect_frame(input string req, input int base, input bit deliver,
                                input logic [15:0] w);
        chk(req, got_cnt - base, deliver ? 1 : 0);
        if (deliver) chk(req, got_word, w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int base;
        logic [15:0] w;
        logic [63:0] bits;
        void'($urandom(32'd20240611));
        wait_clk(6);
        rst_n = 1'b1;
        wait_clk(4);

        // R1: reset state
        chk("R1 word_valid", word_valid, 0);
        chk("R1 chain_out", chain_out, 0);
        chk("R1 no word", got_cnt, 0);

        // R10 / R1: delay line, uC mode with FS high so no frame forms
        chain_en = 1'b1;
        for (int k = 1; k <= 40; k++) begin
            bits[k] = 1'($urandom);
            tick(bits[k]);
            if (k <= 16) chk("R1 cleared delay line", chain_out, 0);
            else chk("R10 delayed bit", chain_out, bits[k-16]);
        end
        // R11: disabled output stays low while bits keep moving
        chain_en = 1'b0;
        for (int k = 0; k < 20; k++) begin
            tick(1'b1);
            chk("R11 chain low", chain_out, 0);
        end

        // R3/R4: uC frame, nothing before FS rises
        base = got_cnt;
        w = 16'hA5C3;
        fs = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 16; i++) tick(w[15-i]);
        wait_clk(20);
        chk("R4 no delivery before FS rise", got_cnt - base, 0);
        fs = 1'b1;
        wait_clk(3*HALF);
        expect_frame("R3 uC frame", base, 1'b1, w);

        // R12: surplus edges in HOLD ignored
        base = got_cnt;
        uc_frame(16'h3E17, 16, 3);
        expect_frame("R12 surplus edges", base, 1'b1, 16'h3E17);

        // R5: early FS rise discards, next frame recovers
        base = got_cnt;
        uc_frame(16'hFFFF, 15, 0);
        expect_frame("R5 abort", base, 1'b0, '0);
        base = got_cnt;
        uc_frame(16'h0001, 16, 0);
        expect_frame("R5 recovery", base, 1'b1, 16'h0001);

        // R7: DSP frame with FS rising early
        mode_uc = 1'b0;
        base = got_cnt;
        dsp_frame(16'h8421, 3);
        expect_frame("R7 DSP early FS", base, 1'b1, 16'h8421);

        // R6: FS falls without an arming edge
        base = got_cnt;
        fs = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 16; i++) tick(1'b1);
        fs = 1'b1;
        wait_clk(3*HALF);
        expect_frame("R6 unarmed", base, 1'b0, '0);

        // R8: mid-frame FS fall restarts the count
        base = got_cnt;
        w = 16'h5A0F;
        tick(1'b0);
        fs = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 5; i++) tick(1'b1);
        fs = 1'b1;
        wait_clk(HALF);
        fs = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 16; i++) tick(w[15-i]);
        fs = 1'b1;
        wait_clk(3*HALF);
        expect_frame("R8 restart", base, 1'b1, w);

        // Random frames, both framing modes (R2, R5, R7, R12)
        for (int f = 0; f < 40; f++) begin
            int nb;
            int ex;
            base = got_cnt;
            w = 16'($urandom);
            mode_uc = 1'($urandom);
            if (mode_uc) begin
                nb = ($urandom_range(0, 4) == 0) ? $urandom_range(1, 15) : 16;
                ex = $urandom_range(0, 2);
                uc_frame(w, nb, ex);
                expect_frame("R2 random uC", base, uc_delivers(nb), w);
            end else begin
                dsp_frame(w, $urandom_range(1, 16));
                expect_frame("R7 random DSP", base, 1'b1, w);
            end
            wait_clk(4);
        end

        chk("R9 single-cycle strobe", dbl_cnt, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule